// File: doc/BRIEF.md
# SD Card Identification Sequencer

This block walks a freshly powered SD memory card from idle to the selected transfer state with a 4-bit data bus. It does not drive the CMD line itself. It hands one command at a time to an external command-line engine and reads back that engine's completion signal, its "no response" flag and up to 128 bits of response payload. It applies the card bring-up rules itself: the interface-condition echo check, the operating-condition polling loop with its voltage-window test, and the block-length command that only standard-capacity cards receive. It keeps the card's OCR, relative address, CID and CSD.

Software or a boot controller pulses `start` once after reset. While the sequence runs, the block asks the clock generator for the 400 kHz identification clock. Once the CSD has been read, it asks for the transfer clock. Each command has its own completion timeout. Between operating-condition polls the block waits for a programmable number of cycles. The run ends with exactly one bit of a one-hot result set, and that result stays valid until the next start.

Top module: `sd_ident_seq`

## Requirements
- R1: After reset the block is idle. `result` is 0, `busy` is 0, `cmd_valid` is 0, `card_int_en` is 1 and `bus_4bit` is 0. Nothing happens until `start` is pulsed.
- R2: On an accepted `start`, the block pulses `clk_upd` with `clk_sel`=0, which selects the 400 kHz identification clock. It then issues index 0 with argument 0 and ignores `rsp_none` for that command. Next it issues index 8 with argument 0x000001AA.
- R3: If the index 8 command ends with `rsp_none`, the result is unsupported (`result`=4'b0010). If response bits [11:0] are not 0x1AA, the result is no usable card (`result`=4'b0100).
- R4: The polling loop issues index 55 with argument 0, then index 41 with argument 0x50FF8000. A poll that does not see OCR bit 31 set counts as a miss, and so does a `rsp_none` on either command. After a miss, the next index 55 command appears exactly `retry_gap`+2 cycles after the cycle in which the missed response completed.
- R5: If an index 41 response lacks any bit of the mask 0x00FF8000, the result is no usable card. When MAX_TRIES misses have occurred, the result is I/O error (`result`=4'b1000).
- R6: Once the card is ready, the commands run in this order: index 2 (arg 0, long response), index 3 (arg 0), index 9 (arg {RCA,16'h0}, long response), then index 7 (arg {RCA,16'h0}). The RCA is taken from bits [31:16] of the index 3 response.
- R7: When the index 9 response completes, and before index 7 is issued, `clk_upd` pulses with `clk_sel`=2 (50 MHz) if `hs_support` is 1, or with `clk_sel`=1 (25 MHz) otherwise.
- R8: Index 16 with argument 512 is issued after index 7 only when bit 30 of the captured OCR (card capacity status) is 0.
- R9: To change the bus width, the block first drops `card_int_en`, then issues index 55 with argument {RCA,16'h0}, then index 6 with argument 2. After that it sets `bus_4bit` and reports done (`result`=4'b0001).
- R10: Every command has a timeout of CMD_TIMEOUT cycles. A response that lands in the very cycle the timeout expires is accepted, and one cycle later gives an I/O error. A `rsp_none` on any command other than index 0, index 8 or the polling loop also gives an I/O error.
- R11: `result` is one-hot or zero. It is zero while `busy` is set, and it holds until the next accepted `start`. A `start` pulse during a run is ignored.
- R12: After done, `ocr_q` holds the final index 41 response word, `rca_q` holds the RCA, `cid_q` holds the index 2 payload and `csd_q` holds the index 9 payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted when not busy |
| hs_support | input | 1 | Host supports the 50 MHz transfer clock |
| retry_gap | input | GAP_W | Idle cycles between polling attempts |
| cmd_valid | output | 1 | One-cycle command issue strobe |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_long | output | 1 | A 136-bit response is expected |
| rsp_done | input | 1 | Command-complete strobe from the engine |
| rsp_none | input | 1 | With rsp_done: the card gave no response |
| rsp_data | input | 128 | Response payload; short responses are in [31:0] |
| clk_upd | output | 1 | Clock change request strobe |
| clk_sel | output | 2 | Requested clock: 0 400 kHz, 1 25 MHz, 2 50 MHz |
| card_int_en | output | 1 | Card interrupt enable |
| bus_4bit | output | 1 | 4-bit data width selected |
| ocr_q | output | 32 | Captured OCR |
| rca_q | output | 16 | Captured relative card address |
| cid_q | output | 128 | Captured CID payload |
| csd_q | output | 128 | Captured CSD payload |
| busy | output | 1 | Sequence in progress |
| result | output | 4 | One-hot: [0] done, [1] unsupported, [2] no card, [3] I/O error |

## Verification
The command's completion strobe and the expiry of that command's timeout can fall in the same cycle. The bench provokes this by delaying the response to index 9 by exactly CMD_TIMEOUT+1 cycles after the issue strobe. The run must then go on to a normal done, with the scoreboard seeing the complete command order. The same delay plus one cycle, applied to index 7, must end in an I/O error with no later command.

// File: rtl/sd_ident_pkg.sv
package sd_ident_pkg;

  typedef enum logic [3:0] {
    S_GO, S_IFC, S_APP, S_OPC, S_CID, S_RCA, S_CSD, S_SEL, S_BLEN, S_BAPP, S_BW
  } step_t;

  typedef enum logic [2:0] {
    P_IDLE, P_SEND, P_WAIT, P_GAP, P_END
  } phase_t;

  localparam logic [11:0] IFC_PATTERN = 12'h1AA;
  localparam logic [31:0] OPC_ARG     = 32'h50FF8000;
  localparam logic [31:0] VOLT_MASK   = 32'h00FF8000;
  localparam logic [31:0] BLOCK_BYTES = 32'd512;
  localparam logic [31:0] WIDTH4_ARG  = 32'd2;

  localparam logic [1:0] CLK_ID  = 2'd0;
  localparam logic [1:0] CLK_DEF = 2'd1;
  localparam logic [1:0] CLK_HS  = 2'd2;

  localparam logic [3:0] RES_DONE   = 4'b0001;
  localparam logic [3:0] RES_UNSUP  = 4'b0010;
  localparam logic [3:0] RES_NOCARD = 4'b0100;
  localparam logic [3:0] RES_IOERR  = 4'b1000;

  function automatic logic [5:0] step_index(step_t s);
    case (s)
      S_GO:   return 6'd0;
      S_IFC:  return 6'd8;
      S_APP:  return 6'd55;
      S_OPC:  return 6'd41;
      S_CID:  return 6'd2;
      S_RCA:  return 6'd3;
      S_CSD:  return 6'd9;
      S_SEL:  return 6'd7;
      S_BLEN: return 6'd16;
      S_BAPP: return 6'd55;
      S_BW:   return 6'd6;
      default: return 6'd0;
    endcase
  endfunction

  function automatic logic [31:0] step_arg(step_t s, logic [15:0] rca);
    case (s)
      S_IFC:               return {20'd0, IFC_PATTERN};
      S_OPC:               return OPC_ARG;
      S_CSD, S_SEL, S_BAPP: return {rca, 16'h0000};
      S_BLEN:              return BLOCK_BYTES;
      S_BW:                return WIDTH4_ARG;
      default:             return 32'd0;
    endcase
  endfunction

  function automatic logic step_long(step_t s);
    return (s == S_CID) || (s == S_CSD);
  endfunction

  function automatic logic volt_ok(logic [31:0] ocr);
    return (ocr & VOLT_MASK) == VOLT_MASK;
  endfunction

endpackage

// File: rtl/sd_ident_timer.sv
module sd_ident_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R10
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero);

  // R10
  timer_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !zero);

endmodule

// File: rtl/sd_ident_tries.sv
module sd_ident_tries #(
  parameter int MAX_TRIES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output logic final_try
);
  localparam int TW = $clog2(MAX_TRIES + 1);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (bump)  cnt <= cnt + 1'b1;
  end

  assign final_try = (cnt == TW'(MAX_TRIES - 1));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TW'(MAX_TRIES));

endmodule

// File: rtl/sd_ident_seq.sv
module sd_ident_seq
  import sd_ident_pkg::*;
#(
  parameter int CMD_TIMEOUT = 100000,
  parameter int MAX_TRIES   = 1000,
  parameter int GAP_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hs_support,
  input  logic [GAP_W-1:0] retry_gap,
  output logic             cmd_valid,
  output logic [5:0]       cmd_index,
  output logic [31:0]      cmd_arg,
  output logic             cmd_long,
  input  logic             rsp_done,
  input  logic             rsp_none,
  input  logic [127:0]     rsp_data,
  output logic             clk_upd,
  output logic [1:0]       clk_sel,
  output logic             card_int_en,
  output logic             bus_4bit,
  output logic [31:0]      ocr_q,
  output logic [15:0]      rca_q,
  output logic [127:0]     cid_q,
  output logic [127:0]     csd_q,
  output logic             busy,
  output logic [3:0]       result
);
  localparam int TO_W = $clog2(CMD_TIMEOUT + 1);
  localparam int CW   = (TO_W > GAP_W) ? TO_W : GAP_W;

  phase_t phase;
  step_t  step;

  // named internal events
  logic          go;
  logic          loop_step;
  logic          loop_miss;
  logic          gap_start;
  logic          cmd_expire;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;
  logic          final_try;

  assign go        = start && (phase == P_IDLE || phase == P_END);
  assign loop_step = (step == S_APP) || (step == S_OPC);
  assign loop_miss = (phase == P_WAIT) && rsp_done && loop_step &&
                     (rsp_none || (step == S_OPC && volt_ok(rsp_data[31:0]) && !rsp_data[31]));
  assign gap_start  = loop_miss && !final_try;
  assign cmd_expire = (phase == P_WAIT) && !rsp_done && tmr_zero;
  assign tmr_load   = (phase == P_SEND) || gap_start;
  assign tmr_val    = (phase == P_SEND) ? CW'(CMD_TIMEOUT) : CW'(retry_gap);

  sd_ident_timer #(.W(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sd_ident_tries #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk(clk), .rst_n(rst_n), .clr(go), .bump(loop_miss), .final_try(final_try)
  );

  assign cmd_valid = (phase == P_SEND);
  assign cmd_index = step_index(step);
  assign cmd_arg   = step_arg(step, rca_q);
  assign cmd_long  = step_long(step);
  assign busy      = (phase == P_SEND) || (phase == P_WAIT) || (phase == P_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= P_IDLE;
      step        <= S_GO;
      clk_upd     <= 1'b0;
      clk_sel     <= CLK_ID;
      card_int_en <= 1'b1;
      bus_4bit    <= 1'b0;
      ocr_q       <= '0;
      rca_q       <= '0;
      cid_q       <= '0;
      csd_q       <= '0;
      result      <= '0;
    end else begin
      clk_upd <= 1'b0;
      case (phase)
        P_IDLE, P_END: begin
          if (go) begin
            phase       <= P_SEND;
            step        <= S_GO;
            clk_sel     <= CLK_ID;
            clk_upd     <= 1'b1;
            card_int_en <= 1'b1;
            bus_4bit    <= 1'b0;
            ocr_q       <= '0;
            rca_q       <= '0;
            cid_q       <= '0;
            csd_q       <= '0;
            result      <= '0;
          end
        end
        P_SEND: phase <= P_WAIT;
        P_GAP: begin
          if (tmr_zero) begin
            phase <= P_SEND;
            step  <= S_APP;
          end
        end
        P_WAIT: begin
          if (rsp_done) begin
            if (loop_miss) begin
              if (final_try) begin
                phase  <= P_END;
                result <= RES_IOERR;
              end else begin
                phase <= P_GAP;
              end
            end else if (rsp_none && step != S_GO) begin
              phase  <= P_END;
              result <= (step == S_IFC) ? RES_UNSUP : RES_IOERR;
            end else begin
              phase <= P_SEND;
              case (step)
                S_GO:  step <= S_IFC;
                S_IFC: begin
                  if (rsp_data[11:0] == IFC_PATTERN) step <= S_APP;
                  else begin
                    phase  <= P_END;
                    result <= RES_NOCARD;
                  end
                end
                S_APP: step <= S_OPC;
                S_OPC: begin
                  if (!volt_ok(rsp_data[31:0])) begin
                    phase  <= P_END;
                    result <= RES_NOCARD;
                  end else begin
                    ocr_q <= rsp_data[31:0];
                    step  <= S_CID;
                  end
                end
                S_CID: begin
                  cid_q <= rsp_data;
                  step  <= S_RCA;
                end
                S_RCA: begin
                  rca_q <= rsp_data[31:16];
                  step  <= S_CSD;
                end
                S_CSD: begin
                  csd_q   <= rsp_data;
                  clk_sel <= hs_support ? CLK_HS : CLK_DEF;
                  clk_upd <= 1'b1;
                  step    <= S_SEL;
                end
                S_SEL: begin
                  if (!ocr_q[30]) step <= S_BLEN;
                  else begin
                    card_int_en <= 1'b0;
                    step        <= S_BAPP;
                  end
                end
                S_BLEN: begin
                  card_int_en <= 1'b0;
                  step        <= S_BAPP;
                end
                S_BAPP: step <= S_BW;
                S_BW: begin
                  bus_4bit <= 1'b1;
                  phase    <= P_END;
                  result   <= RES_DONE;
                end
                default: begin
                  phase  <= P_END;
                  result <= RES_IOERR;
                end
              endcase
            end
          end else if (tmr_zero) begin
            phase  <= P_END;
            result <= RES_IOERR;
          end
        end
        default: phase <= P_IDLE;
      endcase
    end
  end

  // R11
  result_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(result));

  // R11
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (result == '0));

  // R11
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> !clk_upd);

  // R2
  issue_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R8
  blen_only_std_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_index == 6'd16) |-> !ocr_q[30]);

  // R9
  width_after_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_4bit) |-> !card_int_en);

  // R10
  expire_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_expire |=> (result == RES_IOERR));

endmodule

// File: tb/sd_ident_seq_test.sv
module sd_ident_seq_test;
  localparam int CMD_TO = 20;
  localparam int TRIES  = 4;
  localparam int GW     = 16;
  localparam logic [127:0] CID_V = 128'h0123456789ABCDEF_FEDCBA9876543210;
  localparam logic [127:0] CSD_V = 128'h400E0032_5B590000_EDC87F80_0A404000;
  localparam logic [15:0]  RCA_V = 16'h4A2B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic hs_support = 1'b0;
  logic [GW-1:0] retry_gap = '0;
  logic cmd_valid;
  logic [5:0] cmd_index;
  logic [31:0] cmd_arg;
  logic cmd_long;
  logic rsp_done = 1'b0;
  logic rsp_none = 1'b0;
  logic [127:0] rsp_data = '0;
  logic clk_upd;
  logic [1:0] clk_sel;
  logic card_int_en, bus_4bit, busy;
  logic [31:0] ocr_q;
  logic [15:0] rca_q;
  logic [127:0] cid_q, csd_q;
  logic [3:0] result;

  always #2 clk = ~clk;

  sd_ident_seq #(.CMD_TIMEOUT(CMD_TO), .MAX_TRIES(TRIES), .GAP_W(GW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .hs_support(hs_support),
    .retry_gap(retry_gap), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
    .cmd_arg(cmd_arg), .cmd_long(cmd_long), .rsp_done(rsp_done),
    .rsp_none(rsp_none), .rsp_data(rsp_data), .clk_upd(clk_upd),
    .clk_sel(clk_sel), .card_int_en(card_int_en), .bus_4bit(bus_4bit),
    .ocr_q(ocr_q), .rca_q(rca_q), .cid_q(cid_q), .csd_q(csd_q),
    .busy(busy), .result(result)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit ended = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboards
  logic [38:0] cmd_q[$];   // {long, index, arg}
  logic [1:0]  clk_q[$];

  // card scenario knobs
  bit          sc_ifc_none;
  logic [31:0] sc_echo;
  int          sc_polls;
  logic [31:0] sc_ocr;
  int          sc_drop_idx;
  int          sc_none_idx;
  int          sc_slow_idx;
  int          sc_slow_dly;
  bit          gap_pend;
  int          miss_cyc;

  task automatic push_cmd(input logic lng, input logic [5:0] idx, input logic [31:0] arg);
    cmd_q.push_back({lng, idx, arg});
  endtask

  task automatic push_loop(input int misses);
    for (int i = 0; i <= misses; i++) begin
      push_cmd(1'b0, 6'd55, 32'd0);
      push_cmd(1'b0, 6'd41, 32'h50FF8000);
    end
  endtask

  task automatic push_flow(input int misses, input bit std_cap, input bit hs);
    push_cmd(1'b0, 6'd0, 32'd0);
    push_cmd(1'b0, 6'd8, 32'h1AA);
    push_loop(misses);
    push_cmd(1'b1, 6'd2, 32'd0);
    push_cmd(1'b0, 6'd3, 32'd0);
    push_cmd(1'b1, 6'd9, {RCA_V, 16'h0});
    push_cmd(1'b0, 6'd7, {RCA_V, 16'h0});
    if (std_cap) push_cmd(1'b0, 6'd16, 32'd512);
    push_cmd(1'b0, 6'd55, {RCA_V, 16'h0});
    push_cmd(1'b0, 6'd6, 32'd2);
    clk_q.push_back(2'd0);
    clk_q.push_back(hs ? 2'd2 : 2'd1);
  endtask

  // card model and command monitor
  always @(negedge clk) begin
    rsp_done = 1'b0;
    rsp_none = 1'b0;
    if (cmd_valid) begin : serve
      logic [5:0] idx;
      logic [38:0] e;
      int d;
      idx = cmd_index;
      if (cmd_q.size() == 0) begin
        check(1'b0, "R6 unexpected command index", 128'(idx), 128'h0);
      end else begin
        e = cmd_q.pop_front();
        check({cmd_long, cmd_index, cmd_arg} == e, "R6 command order/argument",
              128'({cmd_long, cmd_index, cmd_arg}), 128'(e));
      end
      if (idx == 6'd55 && gap_pend) begin
        gap_pend = 1'b0;
        check(cyc - miss_cyc == int'(retry_gap) + 2, "R4 retry gap",
              128'(cyc - miss_cyc), 128'(int'(retry_gap) + 2));
      end
      if (int'(idx) != sc_drop_idx) begin
        d = (int'(idx) == sc_slow_idx) ? sc_slow_dly : 2;
        repeat (d) @(negedge clk);
        rsp_data = '0;
        rsp_none = (int'(idx) == sc_none_idx);
        case (idx)
          6'd0:  rsp_none = 1'b1;
          6'd8:  begin rsp_none = sc_ifc_none; rsp_data[31:0] = sc_echo; end
          6'd55: rsp_data[31:0] = 32'h0000_0120;
          6'd41: begin
            if (sc_polls > 0) begin
              sc_polls--;
              rsp_data[31:0] = 32'h00FF8000;
              gap_pend = 1'b1;
              miss_cyc = cyc;
            end else rsp_data[31:0] = sc_ocr;
          end
          6'd2:  rsp_data = CID_V;
          6'd3:  rsp_data[31:0] = {RCA_V, 16'h0500};
          6'd9:  rsp_data = CSD_V;
          default: rsp_data[31:0] = 32'h0000_0900;
        endcase
        rsp_done = 1'b1;
      end
    end
  end

  // clock request monitor
  always @(negedge clk) begin
    if (clk_upd) begin
      if (clk_q.size() == 0) check(1'b0, "R7 unexpected clock request", 128'(clk_sel), 128'h0);
      else begin : cpop
        logic [1:0] ec;
        ec = clk_q.pop_front();
        check(clk_sel == ec, "R2 R7 clock select", 128'(clk_sel), 128'(ec));
      end
    end
  end

  task automatic set_case(input logic [31:0] ocr, input int polls);
    sc_ifc_none = 1'b0; sc_echo = 32'h1AA; sc_polls = polls; sc_ocr = ocr;
    sc_drop_idx = -1; sc_none_idx = -1; sc_slow_idx = -1; sc_slow_dly = 2;
    gap_pend = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic finish_case(input logic [3:0] exp_res, input string tag);
    int w;
    w = 0;
    while (result == 4'd0 && w < 5000) begin
      @(negedge clk); w++;
    end
    check(result == exp_res, tag, 128'(result), 128'(exp_res));
    repeat (40) @(negedge clk);
    check(cmd_q.size() == 0, {tag, " all commands seen"}, 128'(cmd_q.size()), 128'h0);
    check(clk_q.size() == 0, "R7 all clock requests seen", 128'(clk_q.size()), 128'h0);
    cmd_q.delete();
    clk_q.delete();
  endtask

  initial begin
    set_case(32'h80FF8000, 0);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(result == 4'd0 && !busy && !cmd_valid, "R1 idle after reset", 128'({result, busy, cmd_valid}), 128'h0);
    check(card_int_en && !bus_4bit, "R1 interrupt enable and width", 128'({card_int_en, bus_4bit}), 128'h2);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!cmd_valid && !busy, "R1 nothing without start", 128'({cmd_valid, busy}), 128'h0);

    // standard capacity, high speed, two misses, gap 3
    set_case(32'h80FF8000, 2);
    hs_support = 1'b1; retry_gap = 16'd3;
    push_flow(2, 1'b1, 1'b1);
    pulse_start();
    finish_case(4'b0001, "R9 done standard capacity");
    check(bus_4bit && !card_int_en, "R9 width set interrupt masked", 128'({bus_4bit, card_int_en}), 128'h2);
    check(ocr_q == 32'h80FF8000, "R12 OCR", 128'(ocr_q), 128'h80FF8000);
    check(rca_q == RCA_V, "R12 RCA", 128'(rca_q), 128'(RCA_V));
    check(cid_q == CID_V, "R12 CID", cid_q, CID_V);
    check(csd_q == CSD_V, "R12 CSD", csd_q, CSD_V);
    check(result == 4'b0001, "R11 result held", 128'(result), 128'h1);

    // high capacity, default speed, gap 0, tie on index 9, start while busy
    set_case(32'hC0FF8000, 1);
    hs_support = 1'b0; retry_gap = 16'd0;
    sc_slow_idx = 9; sc_slow_dly = CMD_TO + 1;
    push_flow(1, 1'b0, 1'b0);
    pulse_start();
    repeat (6) @(negedge clk);
    check(busy && result == 4'd0, "R11 busy during run", 128'({busy, result}), 128'h10);
    pulse_start();
    finish_case(4'b0001, "R10 R8 done high capacity with tie");

    // late response on index 7
    set_case(32'hC0FF8000, 0);
    sc_slow_idx = 7; sc_slow_dly = CMD_TO + 2;
    push_cmd(1'b0, 6'd0, 32'd0); push_cmd(1'b0, 6'd8, 32'h1AA); push_loop(0);
    push_cmd(1'b1, 6'd2, 32'd0); push_cmd(1'b0, 6'd3, 32'd0);
    push_cmd(1'b1, 6'd9, {RCA_V, 16'h0}); push_cmd(1'b0, 6'd7, {RCA_V, 16'h0});
    clk_q.push_back(2'd0); clk_q.push_back(2'd1);
    pulse_start();
    finish_case(4'b1000, "R10 late response error");

    // no response to index 8
    set_case(32'h80FF8000, 0);
    sc_ifc_none = 1'b1;
    push_cmd(1'b0, 6'd0, 32'd0); push_cmd(1'b0, 6'd8, 32'h1AA);
    clk_q.push_back(2'd0);
    pulse_start();
    finish_case(4'b0010, "R3 unsupported");

    // echo mismatch
    set_case(32'h80FF8000, 0);
    sc_echo = 32'h1AB;
    push_cmd(1'b0, 6'd0, 32'd0); push_cmd(1'b0, 6'd8, 32'h1AA);
    clk_q.push_back(2'd0);
    pulse_start();
    finish_case(4'b0100, "R3 echo mismatch");

    // voltage window missing
    set_case(32'h80FF0000, 0);
    push_cmd(1'b0, 6'd0, 32'd0); push_cmd(1'b0, 6'd8, 32'h1AA); push_loop(0);
    clk_q.push_back(2'd0);
    pulse_start();
    finish_case(4'b0100, "R5 voltage window");

    // attempts exhausted
    set_case(32'h80FF8000, 1000);
    retry_gap = 16'd1;
    push_cmd(1'b0, 6'd0, 32'd0); push_cmd(1'b0, 6'd8, 32'h1AA); push_loop(TRIES - 1);
    clk_q.push_back(2'd0);
    pulse_start();
    finish_case(4'b1000, "R5 attempts exhausted");

    // dropped response to index 2
    set_case(32'h80FF8000, 0);
    sc_drop_idx = 2;
    push_cmd(1'b0, 6'd0, 32'd0); push_cmd(1'b0, 6'd8, 32'h1AA); push_loop(0);
    push_cmd(1'b1, 6'd2, 32'd0);
    clk_q.push_back(2'd0);
    pulse_start();
    finish_case(4'b1000, "R10 timeout");

    // no response to index 3
    set_case(32'h80FF8000, 0);
    sc_none_idx = 3;
    push_cmd(1'b0, 6'd0, 32'd0); push_cmd(1'b0, 6'd8, 32'h1AA); push_loop(0);
    push_cmd(1'b1, 6'd2, 32'd0); push_cmd(1'b0, 6'd3, 32'd0);
    clk_q.push_back(2'd0);
    pulse_start();
    finish_case(4'b1000, "R10 missing response");

    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule